// File: doc/BRIEF.md
# NAND page array with spare area

This block is the storage core of a NAND flash model. It holds a fixed number of pages. Each page is a row made of a data area and a spare area, and the spare area is one thirty-second of the data area. A command front end sends it one of three jobs: load, program or erase.

- A load streams the bytes of one page, from a starting column to the end of that page's spare area.
- A program copies bytes from the front end's write buffer into a page at a column.
- An erase sets a whole power-of-two-aligned block of pages to 0xFF.

Every job moves exactly one byte per clock. While a job is moving bytes the block raises `busy`, so the front end can report busy in its status.

The caller gives a byte address. Its low bits are the column and its upper bits are the page index. An extra offset is added to the column, which lets the caller start inside the spare area. A job that names a page past the last one is accepted but does nothing. The default parameters give a small-page array. A large-page setup uses a page shift of 11 and a block shift of 6.

Top module: `nand_page_store`

## Requirements
- R1: After synchronous reset `req_ready` is 1, `busy` is 0 and `rd_valid` is 0. Reset leaves the stored bytes unchanged.
- R2: Every stored byte reads as 0xFF until it is programmed.
- R3: A row is 2^PAGE_SHIFT data bytes followed at once by 2^(PAGE_SHIFT-5) spare bytes.
  - Page n occupies row n.
  - The page index is `req_addr` shifted right by the column width: 8 bits when PAGE_SHIFT is 9 or less, otherwise 16 bits.
  - The column is the bits below the page index.
- R4: Load (`req_op`=0) emits one byte per cycle on `rd_data` with `rd_valid`.
  - The bytes run from row position start = column + `req_ofs` up to the row end.
  - A start at or beyond the row length emits nothing.
- R5: Program (`req_op`=1) stores `buf_byte` at row position start+k, where `buf_idx`=k and k counts from 0.
  - It stores min(`req_len`, row length - start) bytes.
  - Bytes past the row end are dropped.
- R6: Erase (`req_op`=2) clears the low BLOCK_SHIFT bits of the page index. It then writes 0xFF over all 2^BLOCK_SHIFT rows of that block.
- R7: A job whose page index (after alignment, for erase) is PAGE_COUNT or more does nothing. It raises no `busy`, emits no bytes and changes no stored byte. The same holds for `req_op`=3.
- R8: `busy` stays high for exactly one cycle per byte the job moves. `req_ready` is low whenever `busy` is high, so no new job is taken during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Job request strobe |
| req_ready | output | 1 | High when a job can be taken |
| req_op | input | 2 | 0 load, 1 program, 2 erase, 3 no operation |
| req_addr | input | ADDR_SHIFT+clog2(PAGE_COUNT)+1 | Byte address: page index above the column |
| req_ofs | input | PAGE_SHIFT+1 | Extra offset added to the column |
| req_len | input | clog2(row+1) | Number of bytes to program |
| buf_idx | output | clog2(row+1) | Index of the write-buffer byte wanted this cycle |
| buf_byte | input | 8 | Write-buffer byte at `buf_idx` |
| rd_valid | output | 1 | Load byte present on `rd_data` |
| rd_data | output | 8 | Loaded byte |
| busy | output | 1 | High during each byte-moving cycle |

## Verification
The properties assume the following about the inputs:
- Reset is applied before the first request.
- PAGE_COUNT is a multiple of the block size, so an out-of-range page stays out of range after erase alignment.
- `buf_byte` follows `buf_idx` within the same cycle.

The stimulus changes its inputs only on the falling clock edge. It raises a request only while `req_ready` is high and keeps the page count at eight with two-page blocks. The write buffer is a combinational function of `buf_idx` and a per-job seed, which meets the same-cycle rule.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_MOVE = 1'b1
    } seq_e;

    typedef struct packed {
        seq_e st;
        op_e  op;
    } ctl_t;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    // column field width picked from page size
    function automatic int col_bits(input int page_shift);
        return (page_shift <= 9) ? 8 : 16;
    endfunction

    // data plus spare bytes of one row
    function automatic int row_bytes(input int page_shift);
        return (1 << page_shift) + (1 << (page_shift - 5));
    endfunction

endpackage

// File: rtl/nps_decode.sv
module nps_decode
    import nps_pkg::*;
#(
    parameter int PAGE_COUNT  = 8,
    parameter int BLOCK_SHIFT = 1,
    parameter int ROW         = 264,
    parameter int ASH         = 8,
    parameter int AW          = 12,
    parameter int OW          = 9,
    parameter int LW          = 9,
    parameter int MW          = 12,
    parameter int CW          = 12
) (
    input  op_e             op,
    input  logic [AW-1:0]   addr,
    input  logic [OW-1:0]   ofs,
    input  logic [LW-1:0]   len,
    output logic            job_ok,
    output logic [MW-1:0]   job_base,
    output logic [CW-1:0]   job_len
);

    localparam logic [31:0] ROW_U   = 32'(ROW);
    localparam logic [31:0] BLK_PG  = 32'(1) << BLOCK_SHIFT;
    localparam logic [31:0] BLK_LEN = ROW_U * BLK_PG;
    localparam logic [31:0] PG_LIM  = 32'(PAGE_COUNT);

    logic [31:0] page, start, room, moved, aligned;
    logic        in_range;

    always_comb begin
        page    = 32'(addr[AW-1:ASH]);
        start   = 32'(addr[ASH-1:0]) + 32'(ofs);
        room    = (start < ROW_U) ? (ROW_U - start) : 32'd0;
        aligned = page & ~(BLK_PG - 32'd1);
        in_range = 1'b0;
        moved    = 32'd0;
        job_base = '0;
        unique case (op)
            OP_LOAD: begin
                in_range = page < PG_LIM;
                moved    = room;
                job_base = MW'(page * ROW_U + start);
            end
            OP_PROG: begin
                in_range = page < PG_LIM;
                moved    = (32'(len) < room) ? 32'(len) : room;
                job_base = MW'(page * ROW_U + start);
            end
            OP_ERASE: begin
                in_range = aligned < PG_LIM;
                moved    = BLK_LEN;
                job_base = MW'(aligned * ROW_U);
            end
            default: begin
                in_range = 1'b0;
            end
        endcase
        job_ok  = in_range && (moved != 32'd0);
        job_len = CW'(moved);
    end

endmodule

// File: rtl/nps_seq.sv
module nps_seq
    import nps_pkg::*;
#(
    parameter int MW = 12,
    parameter int CW = 12,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  op_e           req_op,
    input  logic          job_ok,
    input  logic [MW-1:0] job_base,
    input  logic [CW-1:0] job_len,
    input  logic [7:0]    buf_byte,
    output logic          req_ready,
    output logic          busy,
    output logic [LW-1:0] buf_idx,
    output logic          mem_we,
    output logic          mem_re,
    output logic [MW-1:0] mem_addr,
    output logic [7:0]    mem_wdata
);

    ctl_t          ctl;
    logic [MW-1:0] ptr;
    logic [CW-1:0] remain;
    logic [CW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '{st: SEQ_IDLE, op: OP_NONE};
            ptr    <= '0;
            remain <= '0;
            idx    <= '0;
        end else begin
            unique case (ctl.st)
                SEQ_IDLE: begin
                    if (req_valid && job_ok) begin
                        ctl    <= '{st: SEQ_MOVE, op: req_op};
                        ptr    <= job_base;
                        remain <= job_len;
                        idx    <= '0;
                    end
                end
                SEQ_MOVE: begin
                    ptr    <= ptr + MW'(1);
                    idx    <= idx + CW'(1);
                    remain <= remain - CW'(1);
                    if (remain == CW'(1)) ctl.st <= SEQ_IDLE;
                end
                default: ctl.st <= SEQ_IDLE;
            endcase
        end
    end

    assign req_ready = (ctl.st == SEQ_IDLE);
    assign busy      = (ctl.st == SEQ_MOVE);
    assign buf_idx   = idx[LW-1:0];
    assign mem_re    = busy && (ctl.op == OP_LOAD);
    assign mem_we    = busy && ((ctl.op == OP_PROG) || (ctl.op == OP_ERASE));
    assign mem_addr  = ptr;
    assign mem_wdata = (ctl.op == OP_ERASE) ? BLANK_BYTE : buf_byte;

endmodule

// File: rtl/nps_store.sv
module nps_store
    import nps_pkg::*;
#(
    parameter int DEPTH = 2112,
    parameter int MW    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          re,
    input  logic [MW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          rd_valid,
    output logic [7:0]    rd_data
);

    logic [7:0] cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = BLANK_BYTE;
    end

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        if (re) rd_data <= cells[addr];
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= re;
    end

endmodule

// File: rtl/nand_page_store.sv
module nand_page_store
    import nps_pkg::*;
#(
    parameter int PAGE_SHIFT  = 8,
    parameter int PAGE_COUNT  = 8,
    parameter int BLOCK_SHIFT = 1,
    localparam int ASH   = col_bits(PAGE_SHIFT),
    localparam int ROW   = row_bytes(PAGE_SHIFT),
    localparam int PG_W  = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1,
    localparam int AW    = ASH + PG_W + 1,
    localparam int OW    = PAGE_SHIFT + 1,
    localparam int LW    = $clog2(ROW + 1),
    localparam int TOTAL = ROW * PAGE_COUNT,
    localparam int MW    = $clog2(TOTAL),
    localparam int CW    = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [OW-1:0] req_ofs,
    input  logic [LW-1:0] req_len,
    output logic [LW-1:0] buf_idx,
    input  logic [7:0]    buf_byte,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          busy
);

    op_e           op;
    logic          job_ok;
    logic [MW-1:0] job_base;
    logic [CW-1:0] job_len;
    logic          mem_we, mem_re;
    logic [MW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    assign op = op_e'(req_op);

    nps_decode #(
        .PAGE_COUNT(PAGE_COUNT), .BLOCK_SHIFT(BLOCK_SHIFT), .ROW(ROW),
        .ASH(ASH), .AW(AW), .OW(OW), .LW(LW), .MW(MW), .CW(CW)
    ) u_decode (
        .op(op), .addr(req_addr), .ofs(req_ofs), .len(req_len),
        .job_ok(job_ok), .job_base(job_base), .job_len(job_len)
    );

    nps_seq #(.MW(MW), .CW(CW), .LW(LW)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(op),
        .job_ok(job_ok), .job_base(job_base), .job_len(job_len),
        .buf_byte(buf_byte), .req_ready(req_ready), .busy(busy),
        .buf_idx(buf_idx), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    nps_store #(.DEPTH(TOTAL), .MW(MW)) u_store (
        .clk(clk), .rst(rst), .we(mem_we), .re(mem_re), .addr(mem_addr),
        .wdata(mem_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
    parameter int PAGE_COUNT = 8,
    parameter int ASH        = 8,
    parameter int AW         = 12,
    parameter int LW         = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_op,
    input logic [AW-1:0] req_addr,
    input logic [LW-1:0] buf_idx,
    input logic          rd_valid,
    input logic          busy
);

    // R8: no job accepted while bytes are moving
    a_r8_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    // R4: a loaded byte only follows a moving cycle
    a_r4_rdvalid_after_busy: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(busy));

    // R5: buffer index steps by one per moved byte
    a_r5_bufidx_steps: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (buf_idx == LW'($past(buf_idx) + 1'b1)));

    // R7: page past the end is dropped
    a_r7_oob_no_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (32'(req_addr[AW-1:ASH]) >= 32'(PAGE_COUNT)))
            |=> !busy);

    // R7: no-operation code starts nothing
    a_r7_noop_no_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_op == 2'd3)) |=> !busy);

endmodule

bind nand_page_store nps_checker #(
    .PAGE_COUNT(PAGE_COUNT), .ASH(ASH), .AW(AW), .LW(LW)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .buf_idx(buf_idx),
    .rd_valid(rd_valid), .busy(busy)
);

// File: tb/nand_page_store_tb.sv
module nand_page_store_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PS    = 8;
    localparam int PAGES = 8;
    localparam int BSH   = 1;
    localparam int ASH   = 8;
    localparam int ROW   = 264;
    localparam int BLK   = 1 << BSH;
    localparam int AW    = 12;
    localparam int OW    = 9;
    localparam int LW    = 9;
    localparam int TOTAL = ROW * PAGES;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  page;
        logic [15:0] col;
        logic [9:0]  ofs;
        logic [9:0]  len;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd5, 16'd0,   10'd0,   10'd0,   8'd0},  // R2 untouched page
        '{2'd2, 8'd1, 16'd0,   10'd0,   10'd0,   8'd0},  // erase block 0
        '{2'd1, 8'd1, 16'd200, 10'd0,   10'd64,  8'd1},  // R3 into spare
        '{2'd0, 8'd1, 16'd190, 10'd0,   10'd0,   8'd0},
        '{2'd1, 8'd0, 16'd0,   10'd256, 10'd20,  8'd2},  // truncated at row end
        '{2'd0, 8'd0, 16'd250, 10'd0,   10'd0,   8'd0},
        '{2'd0, 8'd1, 16'd0,   10'd264, 10'd0,   8'd0},  // start at row end
        '{2'd1, 8'd8, 16'd0,   10'd0,   10'd16,  8'd3},  // beyond last page
        '{2'd0, 8'd0, 16'd0,   10'd0,   10'd0,   8'd0},  // no aliasing
        '{2'd1, 8'd3, 16'd10,  10'd5,   10'd30,  8'd4},
        '{2'd1, 8'd2, 16'd0,   10'd0,   10'd264, 8'd5},
        '{2'd0, 8'd2, 16'd0,   10'd0,   10'd0,   8'd0},
        '{2'd2, 8'd3, 16'd0,   10'd0,   10'd0,   8'd0},  // aligns to page 2
        '{2'd0, 8'd2, 16'd0,   10'd0,   10'd0,   8'd0},
        '{2'd0, 8'd3, 16'd0,   10'd0,   10'd0,   8'd0},
        '{2'd0, 8'd1, 16'd190, 10'd0,   10'd0,   8'd0},
        '{2'd3, 8'd0, 16'd0,   10'd0,   10'd0,   8'd0},  // no-op code
        '{2'd0, 8'd9, 16'd0,   10'd0,   10'd0,   8'd0},  // load beyond end
        '{2'd1, 8'd7, 16'd255, 10'd1,   10'd3,   8'd6}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd3;
    logic [AW-1:0] req_addr = '0;
    logic [OW-1:0] req_ofs = '0;
    logic [LW-1:0] req_len = '0;
    logic [LW-1:0] buf_idx;
    logic [7:0]    buf_byte;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          busy;

    logic [7:0] ref_mem [TOTAL];
    logic [7:0] cap [ROW];
    int         cap_n = 0;
    int         busy_n = 0;
    logic [7:0] cur_seed = 8'd0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_page_store u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_ofs(req_ofs),
        .req_len(req_len), .buf_idx(buf_idx), .buf_byte(buf_byte),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [7:0] pat(input logic [7:0] s, input int i);
        return 8'(((int'(s) * 37) + (i * 11) + 3) ^ (i >> 3));
    endfunction

    assign buf_byte = pat(cur_seed, int'(buf_idx));

    always @(negedge clk) begin
        if (rd_valid) begin
            if (cap_n < ROW) cap[cap_n] = rd_data;
            cap_n++;
        end
        if (busy) busy_n++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // expected byte count and start position from the requirements
    task automatic expect_job(input vec_t v, output int el, output int base);
        int pg, start, room, al;
        pg    = int'(v.page);
        start = int'(v.col) + int'(v.ofs);
        room  = (start < ROW) ? ROW - start : 0;
        el    = 0;
        base  = pg * ROW + start;
        case (v.op)
            2'd0: el = (pg < PAGES) ? room : 0;
            2'd1: el = (pg < PAGES) ? ((int'(v.len) < room) ? int'(v.len) : room) : 0;
            2'd2: begin
                al   = pg & ~(BLK - 1);
                el   = (al < PAGES) ? ROW * BLK : 0;
                base = al * ROW;
            end
            default: el = 0;
        endcase
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        cur_seed  = v.seed;
        req_op    = v.op;
        req_addr  = AW'((int'(v.page) << ASH) | int'(v.col));
        req_ofs   = OW'(v.ofs);
        req_len   = LW'(v.len);
        cap_n     = 0;
        busy_n    = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int el, base, bad, first_i;
        string tag;
        expect_job(v, el, base);
        tag = (el == 0) ? "R7" : (v.op == 2'd0) ? "R4" : (v.op == 2'd1) ? "R5" : "R6";
        issue(v);
        chk(busy_n == el, "R8", {tag, " busy cycles"}, busy_n, el);
        if (v.op == 2'd0) begin
            chk(cap_n == el, tag, "loaded byte count", cap_n, el);
            bad = 0;
            first_i = -1;
            for (int i = 0; i < el && i < cap_n && i < ROW; i++) begin
                if (cap[i] !== ref_mem[base + i]) begin
                    bad++;
                    if (first_i < 0) first_i = i;
                end
            end
            if (first_i >= 0)
                chk(1'b0, tag, "first bad byte value", int'(cap[first_i]),
                    int'(ref_mem[base + first_i]));
            else
                chk(1'b1, tag, "byte values", 0, 0);
        end else if (v.op == 2'd1) begin
            for (int k = 0; k < el; k++) ref_mem[base + k] = pat(v.seed, k);
        end else if (v.op == 2'd2) begin
            for (int k = 0; k < el; k++) ref_mem[base + k] = 8'hFF;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        vec_t v;
        for (int i = 0; i < TOTAL; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);

        for (int n = 0; n < NV; n++) run_vec(VECS[n]);

        // R3 spare bytes of the last page sit right after its data
        v = '{2'd0, 8'd7, 16'd0, 10'd256, 10'd0, 8'd0};
        run_vec(v);

        // R8 ready low while an erase is moving bytes
        @(negedge clk);
        req_op = 2'd2; req_addr = AW'(6 << ASH); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1 && req_ready == 1'b0, "R8", "ready during busy",
            int'(req_ready), 0);
        while (busy) @(negedge clk);
        @(negedge clk);
        for (int k = 6 * ROW; k < 8 * ROW; k++) ref_mem[k] = 8'hFF;

        // R1 reset in the middle of a load keeps contents
        @(negedge clk);
        req_op = 2'd0; req_addr = AW'(1 << ASH); req_ofs = '0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0 && req_ready == 1'b1, "R1", "idle after mid-job reset",
            int'(busy), 0);
        chk(rd_valid == 1'b0, "R1", "no byte after mid-job reset", int'(rd_valid), 0);
        v = '{2'd0, 8'd1, 16'd190, 10'd0, 10'd0, 8'd0};
        run_vec(v);

        finish_run();
    end

endmodule